// File: doc/BRIEF.md
# Audio Buffer Fill-Level Rate Feedback Controller

This block sits between a packet-based audio receiver and a DAC that pulls samples at the pace of its own accurate local clock. Received samples go into a FIFO sized for a few milliseconds of audio. The DAC side reads that FIFO through a read strobe. Both sides share one clock domain, and the strobe acts as the clock enable of the consumer.

Once per packet interval the block looks at how full the FIFO is. It then produces a fixed-point samples-per-packet request for the host. When the buffer drains below its midpoint, the request rises above the nominal packet size. When the buffer fills past the midpoint, the request falls below it. The producer is steered this way and is never throttled directly.

An empty buffer is an error. The block mutes its output and waits for the buffer to refill. A full buffer is also an error, and the block drops the excess input. Each error sets its own sticky flag.

The write port uses a valid/ready handshake. `in_ready` stays high after reset, so the block never applies back-pressure, and a sample presented while the FIFO is full is discarded. The producer must instead be steered through the feedback value.

Top module: `audio_rate_fb`

## Requirements
- R1: After reset, `fb_value` equals NOMINAL·2^FRAC (48·256 = 12288 by default), `fb_valid`, `underrun` and `overrun` are low, `out_data` is zero, `in_ready` is high, and the output starts muted.
- R2: Samples written with `in_valid` high are delivered on `out_data` in write order, one per unmuted `rd_en` cycle, visible in the cycle after the strobe.
- R3: A write made while the FIFO holds DEPTH samples (64 by default) is dropped, and it sets `overrun`, which stays high until reset.
- R4: An `rd_en` strobe taken while unmuted and empty has three effects: `out_data` becomes zero, `underrun` is set and stays high until reset, and the output enters the muted state.
- R5: While muted, `rd_en` yields zero samples and consumes nothing. Muting ends one cycle after the fill level reaches RECOVER (DEPTH/2 = 32 by default).
- R6: `fb_value` changes only in the cycle after a `pkt_tick` pulse, and `fb_valid` pulses high for exactly that cycle.
- R7: `fb_value` is unsigned fixed point with FRAC (8) fraction bits. On a tick with level L below the target T = DEPTH/2, the value becomes NOMINAL·2^FRAC + KP·(T−L), with KP = 16 LSB per sample.
- R8: On a tick with level L above the target, `fb_value` becomes NOMINAL·2^FRAC − KP·(L−T).
- R9: On a tick with |T−L| ≤ DEAD (2 by default), `fb_value` keeps its previous value.
- R10: The correction is clamped to ±2^FRAC, so `fb_value` never leaves NOMINAL·2^FRAC ± 256.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Write sample valid |
| in_ready | output | 1 | Write ready, high whenever out of reset |
| in_data | input | DW | Sample from the packet receiver |
| rd_en | input | 1 | DAC sample strobe |
| out_data | output | DW | Sample presented to the DAC |
| pkt_tick | input | 1 | One pulse per packet interval |
| fb_value | output | FBW | Requested samples per packet, FRAC fraction bits |
| fb_valid | output | 1 | Pulse marking a new feedback update |
| underrun | output | 1 | Sticky empty-read error flag |
| overrun | output | 1 | Sticky full-write error flag |

## Verification
On every cycle, the assertions check four things:
- the error flags stay set once raised;
- muted and empty reads produce zero;
- the feedback never leaves its clamped window;
- the feedback moves only after a tick, and never inside the dead band.

Only the bench scenarios show the rest. These cover the sample order through the FIFO, the exact proportional feedback values on both sides of the target, the startup and post-underrun mute that releases at the recovery level, and the identity of the samples kept when an overrun drops input.

// File: rtl/arf_pkg.sv
package arf_pkg;
  // Saturate a signed correction to +/- lim.
  function automatic int sat_corr(input int raw, input int lim);
    if (raw > lim) return lim;
    if (raw < -lim) return -lim;
    return raw;
  endfunction
endpackage

// File: rtl/arf_fifo.sv
module arf_fifo #(
  parameter int DW    = 16,
  parameter int DEPTH = 64,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] head,
  output logic [CW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full  = (level == CW'(DEPTH));
  assign empty = (level == '0);
  assign head  = mem[rptr];

  always_ff @(posedge clk) begin
    if (push) mem[wptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push) wptr <= nxt(wptr);
      if (pop)  rptr <= nxt(rptr);
      case ({push, pop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  // R3: storage can never report more than its capacity
  a_r3_level_bound: assert property (@(posedge clk) disable iff (!rst_n)
    level <= CW'(DEPTH));
  // R2: a pop with nothing to pop never happens
  a_r2_no_empty_pop: assert property (@(posedge clk) disable iff (!rst_n)
    !(pop && empty));
endmodule

// File: rtl/arf_feedback.sv
module arf_feedback #(
  parameter int CW      = 7,
  parameter int FBW     = 14,
  parameter int NOMINAL = 48,
  parameter int FRAC    = 8,
  parameter int KP      = 16,
  parameter int DEAD    = 2,
  parameter int TARGET  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           tick,
  input  logic [CW-1:0]  level,
  output logic [FBW-1:0] fb,
  output logic           fb_valid
);
  localparam int NOM_FP = NOMINAL << FRAC;
  localparam int LIM    = 1 << FRAC;

  int             err;
  int             corr;
  logic           in_band;
  logic [FBW-1:0] fb_next;

  always_comb begin
    err     = TARGET - int'(level);
    corr    = arf_pkg::sat_corr(err * KP, LIM);
    in_band = (err <= DEAD) && (err >= -DEAD);
    fb_next = FBW'(NOM_FP + corr);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fb       <= FBW'(NOM_FP);
      fb_valid <= 1'b0;
    end else begin
      fb_valid <= tick;
      if (tick && !in_band) fb <= fb_next;
    end
  end

  // R10: request stays within one sample of nominal
  a_r10_fb_window: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(fb) >= NOM_FP - LIM) && (int'(fb) <= NOM_FP + LIM));
  // R6: request only moves right after a tick
  a_r6_fb_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(fb));
  // R9: ticks inside the dead band leave the request alone
  a_r9_dead_band: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && (int'(level) >= TARGET - DEAD) && (int'(level) <= TARGET + DEAD))
      |=> $stable(fb));
endmodule

// File: rtl/audio_rate_fb.sv
module audio_rate_fb #(
  parameter int DW      = 16,
  parameter int DEPTH   = 64,
  parameter int NOMINAL = 48,
  parameter int FRAC    = 8,
  parameter int KP      = 16,
  parameter int DEAD    = 2,
  parameter int RECOVER = DEPTH / 2,
  localparam int CW     = $clog2(DEPTH + 1),
  localparam int FBW    = $clog2(((NOMINAL + 1) << FRAC) + 1),
  localparam int TARGET = DEPTH / 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           in_valid,
  output logic           in_ready,
  input  logic [DW-1:0]  in_data,
  input  logic           rd_en,
  output logic [DW-1:0]  out_data,
  input  logic           pkt_tick,
  output logic [FBW-1:0] fb_value,
  output logic           fb_valid,
  output logic           underrun,
  output logic           overrun
);
  logic          push, pop, full, empty, mute;
  logic [DW-1:0] head;
  logic [CW-1:0] level;

  assign push = in_valid && !full;
  assign pop  = rd_en && !mute && !empty;

  arf_fifo #(.DW(DW), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(in_data),
    .pop(pop), .head(head), .level(level), .full(full), .empty(empty)
  );

  arf_feedback #(
    .CW(CW), .FBW(FBW), .NOMINAL(NOMINAL), .FRAC(FRAC),
    .KP(KP), .DEAD(DEAD), .TARGET(TARGET)
  ) u_fb (
    .clk(clk), .rst_n(rst_n), .tick(pkt_tick), .level(level),
    .fb(fb_value), .fb_valid(fb_valid)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      in_ready <= 1'b0;
      out_data <= '0;
      mute     <= 1'b1;
      underrun <= 1'b0;
      overrun  <= 1'b0;
    end else begin
      in_ready <= 1'b1;
      if (in_valid && full) overrun <= 1'b1;
      if (rd_en) begin
        if (mute) begin
          out_data <= '0;
        end else if (empty) begin
          out_data <= '0;
          underrun <= 1'b1;
          mute     <= 1'b1;
        end else begin
          out_data <= head;
        end
      end
      if (mute && (int'(level) >= RECOVER)) mute <= 1'b0;
    end
  end

  // R3: overrun flag is sticky
  a_r3_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |=> overrun);
  // R4: underrun flag is sticky
  a_r4_underrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    underrun |=> underrun);
  // R4: an empty read while live yields silence and raises the flag
  a_r4_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && !mute && empty) |=> (underrun && out_data == '0));
  // R5: muted reads yield silence
  a_r5_mute_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && mute) |=> (out_data == '0));
endmodule

// File: tb/audio_rate_fb_bench.sv
`timescale 1ns/1ps
module audio_rate_fb_bench;
  localparam int DW = 16, DEPTH = 64, NOM_FP = 48 * 256, KP = 16, LIM = 256;
  localparam int T = 32, DEAD = 2, FBW = 14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, rd_en = 1'b0, pkt_tick = 1'b0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, fb_valid, underrun, overrun;
  logic [DW-1:0] out_data;
  logic [FBW-1:0] fb_value;

  always #2.5 clk = ~clk;

  audio_rate_fb u_audio_rate_fb (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .rd_en(rd_en), .out_data(out_data),
    .pkt_tick(pkt_tick), .fb_value(fb_value), .fb_valid(fb_valid),
    .underrun(underrun), .overrun(overrun)
  );

  int tests = 0, fails = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] seq = 16'd1;
  logic m_mute = 1'b1, m_udf = 1'b0, m_ovf = 1'b0;
  int m_fb = NOM_FP;

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_burst(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = seq;
      if (q.size() < DEPTH) q.push_back(seq); else m_ovf = 1'b1;
      seq++;
    end
    @(negedge clk);
    in_valid = 1'b0;
    @(negedge clk);
    if (q.size() >= T) m_mute = 1'b0;
  endtask

  task automatic read_one(input string req);
    int exp;
    @(negedge clk);
    rd_en = 1'b1;
    if (m_mute) exp = 0;
    else if (q.size() == 0) begin exp = 0; m_mute = 1'b1; m_udf = 1'b1; end
    else exp = int'(q.pop_front());
    @(negedge clk);
    rd_en = 1'b0;
    chk(req, int'(out_data), exp);
  endtask

  task automatic tick_chk(input string req);
    int err;
    err = T - q.size();
    if (err > DEAD || err < -DEAD) begin
      int c;
      c = err * KP;
      if (c > LIM) c = LIM;
      if (c < -LIM) c = -LIM;
      m_fb = NOM_FP + c;
    end
    @(negedge clk);
    pkt_tick = 1'b1;
    @(negedge clk);
    pkt_tick = 1'b0;
    chk({req, " fb_valid"}, int'(fb_valid), 1);
    chk({req, " fb_value"}, int'(fb_value), m_fb);
    @(negedge clk);
    chk("R6 fb_valid single pulse", int'(fb_valid), 0);
    chk("R6 fb held after pulse", int'(fb_value), m_fb);
  endtask

  task automatic t_reset;
    chk("R1 fb nominal", int'(fb_value), NOM_FP);
    chk("R1 fb_valid low", int'(fb_valid), 0);
    chk("R1 underrun low", int'(underrun), 0);
    chk("R1 overrun low", int'(overrun), 0);
    chk("R1 out zero", int'(out_data), 0);
    chk("R1 in_ready high", int'(in_ready), 1);
  endtask

  task automatic t_startup_mute;
    write_burst(10);
    read_one("R5 startup muted read is zero");
    chk("R5 muted read no underrun", int'(underrun), 0);
    write_burst(30);
    tick_chk("R8 above target");
  endtask

  task automatic t_order_and_below;
    for (int i = 0; i < 12; i++) read_one("R2 order");
    tick_chk("R7 below target");
    write_burst(3);
    tick_chk("R9 dead band hold");
  endtask

  task automatic t_clamp;
    for (int i = 0; i < 26; i++) read_one("R2 order drain");
    tick_chk("R10 clamp high");
    write_burst(55);
    tick_chk("R10 clamp low");
  endtask

  task automatic t_overrun_underrun;
    write_burst(7);
    chk("R3 overrun flag", int'(overrun), int'(m_ovf));
    chk("R3 overrun set", int'(overrun), 1);
    for (int i = 0; i < DEPTH; i++) read_one("R3 kept samples order");
    read_one("R4 empty read zero");
    chk("R4 underrun flag", int'(underrun), 1);
    write_burst(5);
    read_one("R5 muted after underrun");
    write_burst(30);
    read_one("R5 recovered first sample");
    chk("R3 overrun stays", int'(overrun), 1);
    chk("R4 underrun stays", int'(underrun), 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_startup_mute();
    t_order_and_below();
    t_clamp();
    t_overrun_underrun();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    tests++;
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule